// File: doc/BRIEF.md
# Restoring Binary Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor, one quotient bit per clock, with the restoring method. Each step shifts a 2W-bit partial-remainder register left by one bit and subtracts the divisor from its upper half as a trial. A non-negative difference writes a 1 into the quotient and keeps the difference as the new upper half. A negative difference writes a 0 and leaves the upper half as it was. After W steps the quotient register holds the W-bit quotient and the upper half holds the W-bit remainder.

The block has two modes. In integer mode the dividend is placed in the low half of the register, so both operands are whole numbers. In fraction mode the dividend is placed in the high half, so the quotient has its binary point on the left. A fraction quotient fits in W bits only when the dividend is below the divisor. The block therefore makes one check before any shift and stops with an overflow flag if that check fails. A zero divisor also stops the operation with the overflow flag, in either mode. The caller pulses `start_i` while the block is idle, waits for the single-cycle `done_o`, and reads the results. The results stay on the outputs until the next operation is accepted.

Top module: `rdiv_top`

## Requirements
- R1: In integer mode (`mode_i`=0) with a nonzero divisor, the results are quotient = dividend / divisor and remainder = dividend mod divisor, and the remainder is below the divisor.
- R2: In fraction mode (`mode_i`=1) with dividend < divisor, the results are quotient = floor(dividend·2^W / divisor) and remainder = (dividend·2^W) mod divisor.
- R3: In fraction mode, a dividend greater than or equal to a nonzero divisor (equality included) raises `overflow_o` when `done_o` rises, and no shift step is run.
- R4: A zero divisor raises `overflow_o` in both modes, and no shift step is run.
- R5: For a run without overflow, `done_o` is high in the (W+2)-th cycle after the clock edge that samples `start_i`. For an overflow run, `done_o` is high in the 2nd cycle after that edge.
- R6: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after the accepted start through the `done_o` cycle, and low otherwise.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. The results that follow belong to the operands that were accepted first.
- R8: After reset, `busy_o`, `done_o`, `overflow_o`, `quotient_o` and `remainder_o` are all 0.
- R9: While the block is idle and `start_i` is low, `quotient_o`, `remainder_o` and `overflow_o` keep their values, even when the operand inputs change.
- R10: In fraction mode the trial subtraction includes the bit shifted out of the top of the upper half. Operands near full scale (for example a divisor with its top bit set and a dividend one below it) therefore give the exact results of R2.
- R11: In integer mode with a nonzero divisor, `overflow_o` is 0 at `done_o`, and a new run clears an overflow left over from an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| mode_i | input | 1 | 0 = integer division, 1 = fraction division |
| dividend_i | input | W | Dividend, sampled with the start |
| divisor_i | input | W | Divisor, sampled with the start |
| busy_o | output | 1 | An operation is in progress (through the done cycle) |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| quotient_o | output | W | Quotient; not meaningful when overflow_o is set |
| remainder_o | output | W | Remainder; not meaningful when overflow_o is set |
| overflow_o | output | 1 | The division overflowed or the divisor was zero |

## Verification
A wrong restore decision in any step corrupts the remainder and one quotient bit at the same time, and the damage shows at the next `done_o`, W+2 cycles after the start. For that reason every completion is compared against quotient and remainder values that the bench derives from plain integer division, in both modes. A miscounted step counter shows first as `done_o` rising in the wrong cycle, so the bench measures the latency on every run. An overflow check taken too late shows as a missing flag or as a full-length run where a two-cycle stop was due. Operands near full scale in fraction mode drive the bit carried out of the upper half, and a trial subtracter one bit too narrow gives wrong quotients there.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } rdiv_state_e;

  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } rdiv_mode_e;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   ovf_hit_i,
  output logic                   load_o,
  output logic                   check_o,
  output logic                   step_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [$clog2(W+1)-1:0] cnt_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  rdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign check_o = (state_q == ST_CHECK);
  assign step_o  = (state_q == ST_RUN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign cnt_o   = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CHECK;
          cnt_d   = '0;
        end
      end
      ST_CHECK: begin
        state_d = ovf_hit_i ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (cnt_q < CW'(W))) else $error("step counter beyond W"); // R5

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o) else $error("start not accepted"); // R6

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
  import rdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         check_i,
  input  logic         step_i,
  input  logic         done_i,
  input  logic         mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         ovf_hit_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvsr_o,
  output logic         ovf_o
);

  localparam int SW = W + 2;

  // Trial subtraction over W+1 bits, with one extra bit carrying the sign.
  function automatic logic [SW-1:0] trial_sub(input logic top,
                                               input logic [W-1:0] part,
                                               input logic [W-1:0] dvsr);
    return {1'b0, top, part} - {2'b00, dvsr};
  endfunction

  function automatic logic trial_ok(input logic [SW-1:0] diff);
    return !diff[SW-1];
  endfunction

  logic [W-1:0] hi_q, lo_q, quot_q, dvsr_q;
  logic         ovf_q;
  rdiv_mode_e   mode_q;

  // One restoring step
  logic         shift_out;
  logic [W-1:0] hi_shift, lo_shift;
  logic [SW-1:0] step_diff;
  logic         step_keep;

  assign shift_out = hi_q[W-1];
  assign hi_shift  = {hi_q[W-2:0], lo_q[W-1]};
  assign lo_shift  = {lo_q[W-2:0], 1'b0};
  assign step_diff = trial_sub(shift_out, hi_shift, dvsr_q);
  assign step_keep = trial_ok(step_diff);

  // Pre-iteration overflow detection
  logic [SW-1:0] pre_diff;
  logic          zero_dvsr;
  logic          frac_big;

  assign pre_diff  = trial_sub(1'b0, hi_q, dvsr_q);
  assign zero_dvsr = (dvsr_q == '0);
  assign frac_big  = (mode_q == MODE_FRAC) && trial_ok(pre_diff);
  assign ovf_hit_o = zero_dvsr || frac_big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      quot_q <= '0;
      dvsr_q <= '0;
      ovf_q  <= 1'b0;
      mode_q <= MODE_INT;
    end else if (load_i) begin
      mode_q <= rdiv_mode_e'(mode_i);
      dvsr_q <= divisor_i;
      quot_q <= '0;
      ovf_q  <= 1'b0;
      if (mode_i == MODE_FRAC) begin
        hi_q <= dividend_i;
        lo_q <= '0;
      end else begin
        hi_q <= '0;
        lo_q <= dividend_i;
      end
    end else if (check_i) begin
      ovf_q <= ovf_hit_o;
    end else if (step_i) begin
      lo_q   <= lo_shift;
      hi_q   <= step_keep ? step_diff[W-1:0] : hi_shift;
      quot_q <= {quot_q[W-2:0], step_keep};
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = hi_q;
  assign dvsr_o = dvsr_q;
  assign ovf_o  = ovf_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !ovf_q) |-> (hi_q < dvsr_q)) else $error("remainder not below divisor"); // R1

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (dvsr_q == '0)) |-> ovf_q) else $error("zero divisor without overflow"); // R4

  AST_FRAC_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (check_i && (mode_q == MODE_FRAC) && (hi_q >= dvsr_q)) |=> ovf_q)
    else $error("fraction overflow missed"); // R3

  AST_INT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (mode_q == MODE_INT) && (dvsr_q != '0)) |-> !ovf_q)
    else $error("integer run flagged overflow"); // R11

endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         overflow_o
);

  localparam int CW = $clog2(W + 1);

  logic          load_w, check_w, step_w, ovf_hit_w;
  logic [CW-1:0] cnt_w;
  logic [W-1:0]  dvsr_w;

  rdiv_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ovf_hit_i (ovf_hit_w),
    .load_o    (load_w),
    .check_o   (check_w),
    .step_o    (step_w),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cnt_o     (cnt_w)
  );

  rdiv_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .check_i    (check_w),
    .step_i     (step_w),
    .done_i     (done_o),
    .mode_i     (mode_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .ovf_hit_o  (ovf_hit_w),
    .quot_o     (quotient_o),
    .rem_o      (remainder_o),
    .dvsr_o     (dvsr_w),
    .ovf_o      (overflow_o)
  );

  AST_FULL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !overflow_o) |-> (cnt_w == CW'(W))) else $error("wrong step count"); // R5

  AST_OVF_NO_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overflow_o) |-> (cnt_w == '0)) else $error("overflow run iterated"); // R3

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(dvsr_w)) else $error("operand reloaded while busy"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(overflow_o)))
    else $error("results changed while idle"); // R9

endmodule

// File: tb/rdiv_top_tb.sv
`timescale 1ns/1ps
module rdiv_top_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, overflow_o;
  logic [W-1:0] quotient_o, remainder_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rdiv_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .quotient_o(quotient_o), .remainder_o(remainder_o),
    .overflow_o(overflow_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ovf(input bit m, input int a, input int b);
    return (b == 0) || (m && (a >= b));
  endfunction

  function automatic int exp_quot(input bit m, input int a, input int b);
    int num = m ? (a << W) : a;
    return num / b;
  endfunction

  function automatic int exp_rem(input bit m, input int a, input int b);
    int num = m ? (a << W) : a;
    return num % b;
  endfunction

  // Starts one operation, waits for done and checks results and latency.
  task automatic run_op(input bit m, input int a, input int b, input string req);
    int lat;
    bit ovf;
    @(negedge clk);
    mode_i = m; dividend_i = W'(a); divisor_i = W'(b); start_i = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R6", "busy after start", busy_o, 1);
    while (!done_o && lat < 60) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    ovf = exp_ovf(m, a, b);
    check(lat == (ovf ? 2 : W + 2), "R5", "done latency", lat, ovf ? 2 : W + 2);
    check(overflow_o == ovf, req, "overflow flag", overflow_o, ovf);
    if (!ovf) begin
      check(quotient_o == W'(exp_quot(m, a, b)), req, "quotient", quotient_o, exp_quot(m, a, b));
      check(remainder_o == W'(exp_rem(m, a, b)), req, "remainder", remainder_o, exp_rem(m, a, b));
    end
    @(posedge clk); @(negedge clk);
    check(done_o == 1'b0, "R6", "done one cycle", done_o, 0);
    check(busy_o == 1'b0, "R6", "busy low after done", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] q_hold, r_hold;
    logic         o_hold;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(busy_o == 0 && done_o == 0, "R8", "busy/done after reset", {busy_o, done_o}, 0);
    check(overflow_o == 0, "R8", "overflow after reset", overflow_o, 0);
    check(quotient_o == 0 && remainder_o == 0, "R8", "results after reset",
          {quotient_o, remainder_o}, 0);
    rst_n = 1'b1;

    // R1: integer directed cases
    run_op(1'b0, 45, 6, "R1");
    run_op(1'b0, 255, 1, "R1");
    run_op(1'b0, 0, 5, "R1");
    run_op(1'b0, 7, 200, "R1");
    run_op(1'b0, 255, 255, "R1");
    // R4: zero divisor in both modes
    run_op(1'b0, 99, 0, "R4");
    run_op(1'b1, 0, 0, "R4");
    // R11: integer run after an overflow clears the flag
    run_op(1'b0, 200, 9, "R11");
    // R2: fraction results
    run_op(1'b1, 1, 3, "R2");
    run_op(1'b1, 0, 1, "R2");
    run_op(1'b1, 100, 101, "R2");
    // R10: full-scale fraction operands exercise the shifted-out bit
    run_op(1'b1, 254, 255, "R10");
    run_op(1'b1, 200, 201, "R10");
    run_op(1'b1, 127, 128, "R10");
    // R3: fraction overflow including equality
    run_op(1'b1, 255, 255, "R3");
    run_op(1'b1, 200, 100, "R3");
    run_op(1'b1, 1, 1, "R3");

    // R7: start while busy is ignored
    @(negedge clk);
    mode_i = 1'b0; dividend_i = 8'd100; divisor_i = 8'd7; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    mode_i = 1'b1; dividend_i = 8'd3; divisor_i = 8'd0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    start_i = 1'b0;
    while (!done_o) begin @(posedge clk); @(negedge clk); end
    check(overflow_o == 0, "R7", "late start ignored overflow", overflow_o, 0);
    check(quotient_o == 14, "R7", "late start ignored quotient", quotient_o, 14);
    check(remainder_o == 2, "R7", "late start ignored remainder", remainder_o, 2);
    @(posedge clk); @(negedge clk);

    // R9: idle outputs hold while inputs move
    q_hold = quotient_o; r_hold = remainder_o; o_hold = overflow_o;
    repeat (5) begin
      mode_i = 1'($urandom); dividend_i = W'($urandom); divisor_i = W'($urandom);
      @(posedge clk); @(negedge clk);
    end
    check(quotient_o == q_hold, "R9", "quotient held", quotient_o, q_hold);
    check(remainder_o == r_hold, "R9", "remainder held", remainder_o, r_hold);
    check(overflow_o == o_hold, "R9", "overflow held", overflow_o, o_hold);
    check(busy_o == 0, "R9", "still idle", busy_o, 0);

    // Random mix; fraction runs mostly kept in range
    for (int i = 0; i < 300; i++) begin
      bit m = 1'($urandom);
      int a = int'($urandom % 256);
      int b = int'($urandom % 256);
      if (($urandom % 10) == 0) b = 0;
      if (m && b != 0 && ($urandom % 4) != 0) a = a % b;
      run_op(m, a, b, m ? (exp_ovf(m, a, b) ? "R3" : "R2") : (b == 0 ? "R4" : "R1"));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule